// File: doc/BRIEF.md
# Gated Divided Clock Output

This block produces an auxiliary clock on an output pin by dividing a fixed reference clock by an 8-bit divider setting. A setting of zero selects the largest ratio, 256. For example, with a 24 MHz reference, zero gives 93.75 kHz and any other value N gives 24 MHz / N. The division is exact in whole reference cycles, so the output period is always the configured ratio.

The output runs only while the attached device reports that configuration has finished and the bus is not suspended. Start and stop are aligned to the divider's own period. A pulse is never shortened, and while gated the pin rests low.

A divider of 1 forwards the reference clock itself through a gate that only changes while the reference is low. A new divider value is picked up at the next period boundary, so a change never produces a period that mixes the old and new ratios.

Top module: `gated_clk_divider`

## Requirements
- R1: While `rst` is high and in the cycles after it, with no enable condition met, `clk_out` is low.
- R2: For a divider value N from 2 to 255, `clk_out` repeats every N reference cycles.
- R3: A divider value of 0 gives a period of 256 reference cycles, with 128 cycles high and 128 cycles low.
- R4: Each period starts with its high phase. The high phase lasts ceil(P/2) reference cycles and the low phase lasts floor(P/2), where P is the period.
- R5: A divider value of 1 makes `clk_out` follow the reference: high during the reference high half and low during its low half.
- R6: `clk_out` runs only while `enum_done` is 1 and `suspend` is 0. If the block is idle and this condition is false, `clk_out` stays low.
- R7: When the enable condition falls during a period, that period completes with its full high phase and full low phase. After that, `clk_out` stays low.
- R8: When the enable condition rises, the first pulse has the full high length of the configured divider.
- R9: A change of `div_sel` takes effect at the next period boundary. The period in progress keeps the old high and low lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | DIV_W | Divider value; 0 means 2**DIV_W |
| enum_done | input | 1 | Device configuration complete |
| suspend | input | 1 | Bus suspend status |
| clk_out | output | 1 | Divided, gated clock |

## Verification
The hardest events to reach are those that land inside a running period: disabling the output, or changing the divider, in the middle of a high phase. The stimulus waits for a rising edge on `clk_out` and drives the change in that same cycle. It then measures the remaining high and low run lengths of the old period before it looks at the next one. Randomly chosen dividers are applied through the period boundary in the same way. Transitions into and out of the pass-through ratio are reached by switching the divider while the output is running.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

    localparam int unsigned DEF_DIV_W = 8;

    // Period in reference cycles for a divider code; code 0 maps to 2**w.
    function automatic int unsigned period_of(input int unsigned code, input int unsigned w);
        return (code == 0) ? (32'd1 << w) : code;
    endfunction

    // High phase length: the odd cycle of an odd period goes to the high phase.
    function automatic int unsigned high_len(input int unsigned per);
        return (per + 1) >> 1;
    endfunction

endpackage

// File: rtl/clkout_seq.sv
`timescale 1ns/1ps
module clkout_seq #(
    parameter int unsigned DIV_W = clkout_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_req,
    input  logic [DIV_W-1:0] div_sel,
    output logic             out_q,
    output logic             byp_req
);
    import clkout_pkg::*;

    localparam int unsigned CNT_W = DIV_W + 1;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic active;
        cnt_t per;
        cnt_t cnt;
    } div_state_t;

    div_state_t st, nxt;
    logic       nxt_out;
    cnt_t       sel_per;
    cnt_t       nxt_hi;

    always_comb begin
        sel_per = cnt_t'(period_of(32'(div_sel), DIV_W));
        nxt     = st;
        if (!st.active) begin
            if (en_req) begin
                nxt.active = 1'b1;
                nxt.cnt    = '0;
                nxt.per    = sel_per;
            end
        end else if (st.cnt == st.per - cnt_t'(1)) begin
            // period boundary: the output is low here (or bypassed)
            nxt.cnt = '0;
            if (en_req) begin
                nxt.per = sel_per;
            end else begin
                nxt.active = 1'b0;
            end
        end else begin
            nxt.cnt = st.cnt + cnt_t'(1);
        end
        nxt_hi  = cnt_t'(high_len(32'(nxt.per)));
        nxt_out = nxt.active && (nxt.per != cnt_t'(1)) && (nxt.cnt < nxt_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '{active: 1'b0, per: cnt_t'(1), cnt: '0};
            out_q <= 1'b0;
        end else begin
            st    <= nxt;
            out_q <= nxt_out;
        end
    end

    assign byp_req = st.active && (st.per == cnt_t'(1));

    // R2: the counter never leaves its period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        st.active |-> (st.cnt < st.per));

    // R8: a period that begins from idle starts with its high phase
    p_start_high_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(st.active) && st.per != cnt_t'(1)) |-> out_q);

    // R7: a high phase of a period of 3 or more is never cut to one cycle
    p_no_runt_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_q) && st.per >= cnt_t'(3)) |=> out_q);

    // R9: the period only changes at a boundary
    p_period_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st.active && st.cnt != st.per - cnt_t'(1)) |=> $stable(st.per));

    // R6: an idle divider keeps the output low
    p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        !st.active |-> !out_q);

endmodule

// File: rtl/clkout_bypass.sv
`timescale 1ns/1ps
module clkout_bypass (
    input  logic clk,
    input  logic rst,
    input  logic byp_req,
    output logic byp_en
);
    // Captured on the falling edge so the gate only moves while clk is low.
    always_ff @(negedge clk) begin
        if (rst) begin
            byp_en <= 1'b0;
        end else begin
            byp_en <= byp_req;
        end
    end

    // R5: the gate opens only after a pass-through request was seen
    p_gate_follows_r5: assert property (@(negedge clk) disable iff (rst)
        $rose(byp_en) |-> $past(byp_req));

endmodule

// File: rtl/gated_clk_divider.sv
`timescale 1ns/1ps
module gated_clk_divider #(
    parameter int unsigned DIV_W = clkout_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             enum_done,
    input  logic             suspend,
    output logic             clk_out
);
    logic en_req;
    logic div_q;
    logic byp_req;
    logic byp_en;

    assign en_req = enum_done && !suspend;

    clkout_seq #(.DIV_W(DIV_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .en_req  (en_req),
        .div_sel (div_sel),
        .out_q   (div_q),
        .byp_req (byp_req)
    );

    clkout_bypass u_byp (
        .clk     (clk),
        .rst     (rst),
        .byp_req (byp_req),
        .byp_en  (byp_en)
    );

    assign clk_out = div_q | (clk & byp_en);

    // R5: the divided path is silent while the pass-through gate is open
    p_paths_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        (byp_en && byp_req) |-> !div_q);

endmodule

// File: tb/gated_clk_divider_tb.sv
`timescale 1ns/1ps
module gated_clk_divider_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] div_sel;
    logic       enum_done;
    logic       suspend;
    logic       clk_out;
    logic       smp;
    int         n_chk = 0;
    int         n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    gated_clk_divider u_dut (
        .clk       (clk),
        .rst       (rst),
        .div_sel   (div_sel),
        .enum_done (enum_done),
        .suspend   (suspend),
        .clk_out   (clk_out)
    );

    function automatic int exp_per(input int d);
        return (d == 0) ? 256 : d;
    endfunction
    function automatic int exp_hi(input int d);
        return (exp_per(d) + 1) / 2;
    endfunction
    function automatic int exp_lo(input int d);
        return exp_per(d) / 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sample a quarter period after the rising edge (clk high)
    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
        smp = clk_out;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = smp;
        for (int i = 0; i < 1200; i++) begin
            tick();
            if (smp && !prev) return;
            prev = smp;
        end
    endtask

    // starts on a sample that is high; ends on the next rise
    task automatic runs(output int hi, output int lo);
        hi = 1;
        lo = 0;
        for (int i = 0; i < 1200; i++) begin
            tick();
            if (!smp) break;
            hi++;
        end
        for (int i = 0; i < 1200; i++) begin
            if (smp) break;
            lo++;
            tick();
        end
    endtask

    task automatic count_highs(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (smp) h++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int hi, lo, h, d;
        void'($urandom(32'h1c0ffee));
        smp       = 1'b0;
        rst       = 1'b1;
        div_sel   = 8'd4;
        enum_done = 1'b0;
        suspend   = 1'b0;
        repeat (5) tick();
        check(smp == 1'b0, "R1 reset low", int'(smp), 0);
        rst = 1'b0;
        count_highs(50, h);
        check(h == 0, "R1 low after reset", h, 0);

        // R6: not enumerated, then enumerated but suspended
        count_highs(300, h);
        check(h == 0, "R6 no enum", h, 0);
        enum_done = 1'b1;
        suspend   = 1'b1;
        count_highs(300, h);
        check(h == 0, "R6 suspended", h, 0);

        // R8 first pulse full, R4 even duty
        div_sel = 8'd6;
        suspend = 1'b0;
        wait_rise();
        runs(hi, lo);
        check(hi == 3, "R8 first high", hi, 3);
        check(lo == 3, "R4 even low", lo, 3);

        // R4 odd divider
        div_sel = 8'd7;
        wait_rise();
        runs(hi, lo);
        check(hi == 4 && lo == 3, "R4 odd hi*10+lo", hi*10+lo, 43);

        // R3 divider zero
        div_sel = 8'd0;
        wait_rise();
        runs(hi, lo);
        check(hi == 128, "R3 high", hi, 128);
        check(lo == 128, "R3 low", lo, 128);

        // R2 random dividers
        for (int k = 0; k < 12; k++) begin
            d = $urandom_range(255, 2);
            div_sel = 8'(d);
            wait_rise();
            runs(hi, lo);
            check(hi + lo == exp_per(d), "R2 period", hi + lo, exp_per(d));
            check(hi == exp_hi(d) && lo == exp_lo(d), "R4 split hi*1000+lo",
                  hi*1000+lo, exp_hi(d)*1000+exp_lo(d));
        end
        // R2 largest nonzero
        div_sel = 8'd255;
        wait_rise();
        runs(hi, lo);
        check(hi + lo == 255, "R2 period 255", hi + lo, 255);

        // R9 change inside the high phase
        div_sel = 8'd10;
        wait_rise();
        wait_rise();
        div_sel = 8'd4;
        runs(hi, lo);
        check(hi == 5 && lo == 5, "R9 old period kept hi*10+lo", hi*10+lo, 55);
        runs(hi, lo);
        check(hi == 2 && lo == 2, "R9 new period hi*10+lo", hi*10+lo, 22);

        // R7 stop inside a high phase
        div_sel = 8'd8;
        wait_rise();
        wait_rise();
        suspend = 1'b1;
        runs(hi, lo);
        check(hi == 4, "R7 full last high", hi, 4);
        check(lo >= 600, "R7 held low after stop", lo, 600);

        // R8 restart
        suspend = 1'b0;
        wait_rise();
        runs(hi, lo);
        check(hi == 4 && lo == 4, "R8 restart hi*10+lo", hi*10+lo, 44);

        // R5 pass-through
        div_sel = 8'd1;
        repeat (20) tick();
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #(CLK_P/4);
            check(clk_out == 1'b1, "R5 high half", int'(clk_out), 1);
            #(CLK_P/2);
            check(clk_out == 1'b0, "R5 low half", int'(clk_out), 0);
        end
        enum_done = 1'b0;
        repeat (5) tick();
        h = 0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            #(CLK_P/4);
            if (clk_out) h++;
            #(CLK_P/2);
            if (clk_out) h++;
        end
        check(h == 0, "R6 bypass gated", h, 0);

        // leaving pass-through
        enum_done = 1'b1;
        div_sel   = 8'd3;
        smp       = 1'b0;
        repeat (5) tick();
        wait_rise();
        runs(hi, lo);
        check(hi == 2 && lo == 1, "R4 after bypass hi*10+lo", hi*10+lo, 21);

        summary();
        $finish;
    end

endmodule